// File: doc/BRIEF.md
# Dual-Pattern Serial Detector with Lockout

The block watches a serial bit stream, one bit per rising clock edge. It raises a flag on the cycle in which the most recent three bits form either of two patterns. Pattern A is 0,1,0 and pattern B is 1,0,0, with the oldest bit first. Matches may overlap: the tail of one match can start the next match of either pattern.

Pattern B has a permanent effect on pattern A. Once pattern B has completed, the pattern A flag is silenced until the next reset. The pattern B flag keeps firing on every completion. Both flags are Mealy outputs, so each one is valid in the same cycle as the bit that completes its pattern.

The whole behaviour fits in one machine of eight states, held in a 3-bit register. Five of the states track both patterns before the lockout. The other three track only pattern B after it.

Top module: `dual_pattern_detect`

## Requirements
- R1: A synchronous active-high `rst`, sampled on a rising edge of `clk`, returns the machine to its idle state. In the first cycle after reset both flags are 0.
- R2: `pat_a_hit` is 1 in the cycle where `din` is 0 and the two previously sampled bits were 0 then 1, provided pattern B has not completed since reset. In every other cycle it is 0.
- R3: `pat_b_hit` is 1 in every cycle where `din` is 0 and the two previously sampled bits were 1 then 0. This holds with no lockout of its own, and in every other cycle the flag is 0.
- R4: Once `pat_b_hit` has been 1, `pat_a_hit` stays 0 until the next reset, whatever the input.
- R5: A completion of pattern A places no restriction on later completions of pattern B.
- R6: Matches overlap. The input 0,1,0,0 gives `pat_a_hit` on the third bit and `pat_b_hit` on the fourth. The input 0,1,0,1,0 gives `pat_a_hit` on the third and fifth bits.
- R7: The flags are Mealy outputs. They respond to `din` within the same cycle, without waiting for a clock edge.
- R8: Reset clears the lockout, so pattern A is detected again after it.
- R9: Bits sampled before a reset take no part in matches after it. The history restarts empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `din` is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| pat_a_hit | output | 1 | Completion of 0,1,0 while not locked out |
| pat_b_hit | output | 1 | Completion of 1,0,0 |

## Verification
The checker compares both flags on every cycle against the last three bits seen since reset. These checks cover the pattern conditions, in both directions. The checker also keeps a sticky record of any pattern B hit, so the lockout is checked on every cycle. Some behaviours only the bench scenarios can show. These are that one reset re-enables pattern A after a lockout, that bits from before a reset are forgotten, and that the flags follow `din` within a cycle.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    localparam int STATE_W = 3;

    // Tracked suffix of the input stream; LK_* states follow the lockout.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 3'd0,  // nothing useful yet
        ST_Z       = 3'd1,  // suffix "0"
        ST_ZO      = 3'd2,  // suffix "01"
        ST_O       = 3'd3,  // suffix "1"
        ST_OZ      = 3'd4,  // suffix "10"
        ST_LK_IDLE = 3'd5,  // locked, no useful suffix
        ST_LK_O    = 3'd6,  // locked, suffix "1"
        ST_LK_OZ   = 3'd7   // locked, suffix "10"
    } dpd_state_e;

    typedef struct packed {
        logic a;
        logic b;
    } dpd_hits_t;

    function automatic logic tail_01(dpd_state_e s);
        return s == ST_ZO;
    endfunction

    function automatic logic tail_10(dpd_state_e s);
        return (s == ST_OZ) || (s == ST_LK_OZ);
    endfunction

endpackage

// File: rtl/dpd_state_reg.sv
module dpd_state_reg
    import dpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dpd_state_e d,
    output dpd_state_e q
);
    always_ff @(posedge clk) begin
        if (rst) q <= ST_IDLE;
        else     q <= d;
    end
endmodule

// File: rtl/dpd_next.sv
module dpd_next
    import dpd_pkg::*;
(
    input  dpd_state_e cur,
    input  logic       bit_in,
    output dpd_state_e nxt
);
    always_comb begin
        unique case (cur)
            ST_IDLE:    nxt = bit_in ? ST_O    : ST_Z;
            ST_Z:       nxt = bit_in ? ST_ZO   : ST_Z;
            ST_ZO:      nxt = bit_in ? ST_O    : ST_OZ;
            ST_O:       nxt = bit_in ? ST_O    : ST_OZ;
            ST_OZ:      nxt = bit_in ? ST_ZO   : ST_LK_IDLE;
            ST_LK_IDLE: nxt = bit_in ? ST_LK_O : ST_LK_IDLE;
            ST_LK_O:    nxt = bit_in ? ST_LK_O : ST_LK_OZ;
            ST_LK_OZ:   nxt = bit_in ? ST_LK_O : ST_LK_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dpd_outs.sv
module dpd_outs
    import dpd_pkg::*;
(
    input  dpd_state_e cur,
    input  logic       bit_in,
    output dpd_hits_t  hits
);
    always_comb begin
        hits.a = tail_01(cur) & ~bit_in;
        hits.b = tail_10(cur) & ~bit_in;
    end
endmodule

// File: rtl/dual_pattern_detect.sv
module dual_pattern_detect
    import dpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pat_a_hit,
    output logic pat_b_hit
);
    dpd_state_e state_q;
    dpd_state_e state_d;
    dpd_hits_t  hits;

    dpd_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (state_d),
        .q   (state_q)
    );

    dpd_next u_next (
        .cur    (state_q),
        .bit_in (din),
        .nxt    (state_d)
    );

    dpd_outs u_outs (
        .cur    (state_q),
        .bit_in (din),
        .hits   (hits)
    );

    assign pat_a_hit = hits.a;
    assign pat_b_hit = hits.b;
endmodule

// File: rtl/dpd_checker.sv
module dpd_checker (
    input logic clk,
    input logic rst,
    input logic din,
    input logic pat_a_hit,
    input logic pat_b_hit
);
    logic [1:0] depth;
    logic       b_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth  <= 2'd0;
            b_seen <= 1'b0;
        end else begin
            if (depth != 2'd3) depth <= depth + 2'd1;
            if (pat_b_hit) b_seen <= 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pat_a_hit && !pat_b_hit)); // R1

    AST_A_ONLY_ON_PATTERN: assert property (@(posedge clk) disable iff (rst)
        pat_a_hit |-> (depth >= 2'd2 && !din && $past(din) && !$past(din, 2))); // R2

    AST_A_ON_EVERY_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (depth >= 2'd2 && !b_seen && !din && $past(din) && !$past(din, 2)) |-> pat_a_hit); // R2

    AST_B_ONLY_ON_PATTERN: assert property (@(posedge clk) disable iff (rst)
        pat_b_hit |-> (depth >= 2'd2 && !din && !$past(din) && $past(din, 2))); // R3

    AST_B_ON_EVERY_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (depth >= 2'd2 && !din && !$past(din) && $past(din, 2)) |-> pat_b_hit); // R3

    AST_LOCKOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        b_seen |-> !pat_a_hit); // R4
endmodule

bind dual_pattern_detect dpd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .pat_a_hit (pat_a_hit),
    .pat_b_hit (pat_b_hit)
);

// File: tb/sim_dual_pattern_detect.sv
module sim_dual_pattern_detect;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic pat_a_hit;
    logic pat_b_hit;

    int n_run  = 0;
    int n_fail = 0;

    // Reference model: bits since reset (oldest first, at most two kept) and lock flag
    bit hist[$];
    bit locked;

    always #4 clk = ~clk;

    dual_pattern_detect u0 (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .pat_a_hit (pat_a_hit),
        .pat_b_hit (pat_b_hit)
    );

    function automatic bit exp_a(bit cur);
        return hist.size() == 2 && hist[0] == 1'b0 && hist[1] == 1'b1 && cur == 1'b0 && !locked;
    endfunction

    function automatic bit exp_b(bit cur);
        return hist.size() == 2 && hist[0] == 1'b1 && hist[1] == 1'b0 && cur == 1'b0;
    endfunction

    task automatic check(string tag, bit ea, bit eb);
        n_run++;
        if (pat_a_hit !== ea) begin
            n_fail++;
            $display("FAIL %s: pat_a_hit=%0b expected %0b", tag, pat_a_hit, ea);
        end
        n_run++;
        if (pat_b_hit !== eb) begin
            n_fail++;
            $display("FAIL %s: pat_b_hit=%0b expected %0b", tag, pat_b_hit, eb);
        end
    endtask

    task automatic model_push(bit b);
        if (exp_b(b)) locked = 1'b1;
        hist.push_back(b);
        if (hist.size() > 2) void'(hist.pop_front());
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(bit b, string tag);
        din = b;
        #1;
        check(tag, exp_a(b), exp_b(b));
        model_push(b);
        @(negedge clk);
    endtask

    task automatic send(string bits, string tag);
        for (int i = 0; i < bits.len(); i++) step(bits[i] == "1", tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        hist.delete();
        locked = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        do_reset();

        // R1: idle after reset
        din = 1'b0;
        #1;
        check("R1 reset idle", 1'b0, 1'b0);
        @(negedge clk);
        hist.push_back(1'b0);

        do_reset();
        send("010", "R2 basic pattern A");
        send("11010", "R2 pattern A again");

        // R7: flag follows din inside one cycle
        do_reset();
        send("01", "R7 prefix");
        din = 1'b0;
        #1;
        check("R7 din low", 1'b1, 1'b0);
        din = 1'b1;
        #1;
        check("R7 din high same cycle", 1'b0, 1'b0);
        model_push(1'b1);
        @(negedge clk);

        // R6: overlapping matches
        do_reset();
        send("01010", "R6 overlap A A");
        do_reset();
        send("0100", "R6 R5 overlap A then B");

        // R4 and R3: locked out, B keeps firing
        send("1001001", "R3 repeated B");
        send("010010", "R4 lockout");

        // R8: reset re-enables A
        do_reset();
        send("010", "R8 A after reset");

        // R9: history forgotten across reset
        send("01", "R9 before reset");
        do_reset();
        send("0", "R9 after reset");
        send("10", "R9 fresh pattern");

        // R2 R3 R4: pseudo-random stream, several resets
        for (int r = 0; r < 4; r++) begin
            do_reset();
            lfsr = 16'hACE1 + 16'(r * 977);
            for (int i = 0; i < 200; i++) begin
                step(lfsr[0], "R2 R3 R4 random stream");
                lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule